// File: doc/BRIEF.md
# Privilege and mode state controller

This block keeps track of two things: whether the processor is running ordinary code (thread mode) or an exception handler (handler mode), and whether it runs at the privileged or the user level. It holds a two-bit control word. One bit lowers thread-mode code to the user level. The other bit picks which of two banked stack pointers thread-mode code sees. Both stack pointers live here as well. Each has its own write port, and each is always kept word aligned.

Exception entry and exception return arrive as single-cycle pulses. A nesting counter lets handlers preempt one another, and thread mode comes back only when the last handler has returned. On that return, thread code runs at the level the control word holds. That is the level in force before the exception, unless a handler rewrote it. Handler code is always privileged and always uses the main stack. A return pulse with no handler active is reported on an error output and changes nothing. An entry that would overflow the counter is treated the same way.

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset the block is in thread mode at the privileged level. The control word is 0, the nesting depth is 0, both stack pointers are 0 and the error output is low.
- R2: While the nesting depth is nonzero, handler_mode is 1, user_level is 0 and psp_active is 0, whatever the control word holds.
- R3: A control write from privileged thread mode stores both bits. Bit 0 set selects the user level in thread mode, and bit 1 set selects the process stack in thread mode.
- R4: A control write from user-level thread mode leaves bit 0 at 1, so privilege cannot be raised. Bit 1 is still stored.
- R5: A control write in handler mode stores both bits. Bit 0 then sets the level that thread mode resumes with.
- R6: An entry pulse increments the nesting depth and leaves the control word unchanged. The outputs show handler mode from the next cycle.
- R7: A return pulse in handler mode decrements the depth. Thread mode resumes only when the depth reaches 0, and it resumes at the level given by control bit 0.
- R8: Every stack-pointer write stores the data with its two lowest bits forced to 0. active_sp shows the process stack pointer when in thread mode with control bit 1 set, and the main stack pointer otherwise.
- R9: A return pulse in thread mode raises exc_error for exactly one cycle. It leaves the depth and the control word unchanged.
- R10: An entry pulse at the maximum depth (2^DEPTH_W-1, that is 7 by default) raises exc_error for one cycle and leaves the depth unchanged.
- R11: When entry and return pulses arrive in the same cycle, the entry is taken and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_enter | input | 1 | Exception entry pulse |
| exc_return | input | 1 | Exception return pulse |
| ctrl_we | input | 1 | Control word write enable |
| ctrl_wdata | input | 2 | Control write data: bit 0 user level, bit 1 process stack |
| msp_we | input | 1 | Main stack pointer write enable |
| msp_wdata | input | SP_W | Main stack pointer write data |
| psp_we | input | 1 | Process stack pointer write enable |
| psp_wdata | input | SP_W | Process stack pointer write data |
| handler_mode | output | 1 | 1 while any handler is active |
| user_level | output | 1 | 1 when running at the user level |
| psp_active | output | 1 | 1 when the process stack is the visible one |
| ctrl_value | output | 2 | Stored control word |
| nest_depth | output | DEPTH_W | Current nesting depth |
| exc_error | output | 1 | One-cycle flag for an illegal return or an overflowing entry |
| msp_value | output | SP_W | Main stack pointer |
| psp_value | output | SP_W | Process stack pointer |
| active_sp | output | SP_W | Stack pointer currently visible |

## Verification
The bench starts from each of the four control words and applies each of the four possible writes. It checks that a user-level writer never clears bit 0, which would amount to an escape to privilege. It also checks that a privileged writer is not blocked.

It nests entries up to the full depth and returns one level at a time. A counter that left handler mode early, or that wrapped on overflow, would release thread mode with the wrong level or the wrong stack. Stray returns in thread mode and simultaneous entry and return pulses are driven to catch a depth that underflows, or a flag that sticks or never rises. Stack writes sweep the low address bits so that an unaligned pointer would be seen.

// File: rtl/priv_pkg.sv
package priv_pkg;
    typedef struct packed {
        logic spsel;   // bit 1: process stack in thread mode
        logic npriv;   // bit 0: user level in thread mode
    } ctrl_t;
endpackage

// File: rtl/priv_ctrl_reg.sv
module priv_ctrl_reg
    import priv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  ctrl_t wdata,
    input  logic  in_handler,
    output ctrl_t ctrl_q
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (we) begin
            if (in_handler || !ctrl_q.npriv) begin
                ctrl_d = wdata;
            end else begin
                // user-level writer: privilege bit sticks at user
                ctrl_d.spsel = wdata.spsel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/priv_nest_ctr.sv
module priv_nest_ctr #(
    parameter int DEPTH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enter,
    input  logic               ret,
    output logic [DEPTH_W-1:0] depth,
    output logic               in_handler,
    output logic               err
);
    localparam logic [DEPTH_W-1:0] MAX_DEPTH = '1;

    typedef struct packed {
        logic [DEPTH_W-1:0] depth;
        logic               err;
    } nest_t;

    nest_t nest_d, nest_q;

    always_comb begin
        nest_d     = nest_q;
        nest_d.err = 1'b0;
        if (enter) begin
            if (nest_q.depth == MAX_DEPTH) nest_d.err   = 1'b1;
            else                           nest_d.depth = nest_q.depth + 1'b1;
        end else if (ret) begin
            if (nest_q.depth == '0) nest_d.err   = 1'b1;
            else                    nest_d.depth = nest_q.depth - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) nest_q <= '0;
        else        nest_q <= nest_d;
    end

    assign depth      = nest_q.depth;
    assign in_handler = (nest_q.depth != '0);
    assign err        = nest_q.err;
endmodule

// File: rtl/priv_sp_bank.sv
module priv_sp_bank #(
    parameter int SP_W     = 32,
    parameter int N_SP     = 2,
    parameter int ALIGN_LG = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SP-1:0]           we,
    input  logic [N_SP-1:0][SP_W-1:0] wdata,
    output logic [N_SP-1:0][SP_W-1:0] sp_q
);
    localparam logic [SP_W-1:0] ALIGN_MASK = {{(SP_W-ALIGN_LG){1'b1}}, {ALIGN_LG{1'b0}}};

    logic [N_SP-1:0][SP_W-1:0] sp_d;

    for (genvar g = 0; g < N_SP; g++) begin : g_sp
        always_comb begin
            sp_d[g] = sp_q[g];
            if (we[g]) sp_d[g] = wdata[g] & ALIGN_MASK;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) sp_q[g] <= '0;
            else        sp_q[g] <= sp_d[g];
        end
    end
endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
    import priv_pkg::*;
#(
    parameter int SP_W    = 32,
    parameter int DEPTH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_enter,
    input  logic               exc_return,
    input  logic               ctrl_we,
    input  logic [1:0]         ctrl_wdata,
    input  logic               msp_we,
    input  logic [SP_W-1:0]    msp_wdata,
    input  logic               psp_we,
    input  logic [SP_W-1:0]    psp_wdata,
    output logic               handler_mode,
    output logic               user_level,
    output logic               psp_active,
    output logic [1:0]         ctrl_value,
    output logic [DEPTH_W-1:0] nest_depth,
    output logic               exc_error,
    output logic [SP_W-1:0]    msp_value,
    output logic [SP_W-1:0]    psp_value,
    output logic [SP_W-1:0]    active_sp
);
    localparam int IDX_MAIN = 0;
    localparam int IDX_PROC = 1;

    ctrl_t                  ctrl_q;
    logic                   in_handler;
    logic [1:0][SP_W-1:0]   sp_q;
    logic [1:0][SP_W-1:0]   sp_wdata;
    logic [1:0]             sp_we;

    priv_nest_ctr #(.DEPTH_W(DEPTH_W)) u_nest (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter      (exc_enter),
        .ret        (exc_return),
        .depth      (nest_depth),
        .in_handler (in_handler),
        .err        (exc_error)
    );

    priv_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (ctrl_we),
        .wdata      (ctrl_t'(ctrl_wdata)),
        .in_handler (in_handler),
        .ctrl_q     (ctrl_q)
    );

    assign sp_we[IDX_MAIN]    = msp_we;
    assign sp_we[IDX_PROC]    = psp_we;
    assign sp_wdata[IDX_MAIN] = msp_wdata;
    assign sp_wdata[IDX_PROC] = psp_wdata;

    priv_sp_bank #(.SP_W(SP_W), .N_SP(2), .ALIGN_LG(2)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sp_we),
        .wdata (sp_wdata),
        .sp_q  (sp_q)
    );

    assign handler_mode = in_handler;
    assign user_level   = !in_handler && ctrl_q.npriv;
    assign psp_active   = !in_handler && ctrl_q.spsel;
    assign ctrl_value   = ctrl_q;
    assign msp_value    = sp_q[IDX_MAIN];
    assign psp_value    = sp_q[IDX_PROC];
    assign active_sp    = psp_active ? sp_q[IDX_PROC] : sp_q[IDX_MAIN];
endmodule

// File: rtl/priv_mode_checker.sv
module priv_mode_checker #(
    parameter int SP_W    = 32,
    parameter int DEPTH_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               exc_enter,
    input logic               exc_return,
    input logic               handler_mode,
    input logic               user_level,
    input logic               psp_active,
    input logic [1:0]         ctrl_value,
    input logic [DEPTH_W-1:0] nest_depth,
    input logic               exc_error,
    input logic [SP_W-1:0]    msp_value,
    input logic [SP_W-1:0]    psp_value
);
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (!handler_mode && !user_level && ctrl_value == 2'b00 && !exc_error));

    a_r2_handler_priv: assert property (@(posedge clk) disable iff (!rst_n)
        handler_mode |-> (!user_level && !psp_active));

    a_r4_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (!handler_mode && user_level && !exc_enter) |=> ctrl_value[0]);

    a_r6_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_enter && !handler_mode) |=> (handler_mode && $stable(ctrl_value)));

    a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (msp_value[1:0] == 2'b00 && psp_value[1:0] == 2'b00));

    a_r9_bad_return: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_enter && !handler_mode) |=> (exc_error && !handler_mode && $stable(ctrl_value)));

    a_r11_enter_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_enter && exc_return && !handler_mode) |=> handler_mode);
endmodule

bind priv_mode_ctrl priv_mode_checker #(.SP_W(SP_W), .DEPTH_W(DEPTH_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .exc_enter    (exc_enter),
    .exc_return   (exc_return),
    .handler_mode (handler_mode),
    .user_level   (user_level),
    .psp_active   (psp_active),
    .ctrl_value   (ctrl_value),
    .nest_depth   (nest_depth),
    .exc_error    (exc_error),
    .msp_value    (msp_value),
    .psp_value    (psp_value)
);

// File: tb/tb_priv_mode_ctrl.sv
module tb_priv_mode_ctrl;
    localparam int SP_W    = 32;
    localparam int DEPTH_W = 3;
    localparam int MAXD    = (1 << DEPTH_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exc_enter = 1'b0, exc_return = 1'b0, ctrl_we = 1'b0;
    logic [1:0] ctrl_wdata = '0;
    logic msp_we = 1'b0, psp_we = 1'b0;
    logic [SP_W-1:0] msp_wdata = '0, psp_wdata = '0;
    logic handler_mode, user_level, psp_active, exc_error;
    logic [1:0] ctrl_value;
    logic [DEPTH_W-1:0] nest_depth;
    logic [SP_W-1:0] msp_value, psp_value, active_sp;

    int n_checks = 0;
    int n_errors = 0;

    // bench model
    logic [1:0] m_ctrl;
    int m_depth;
    logic m_err;
    logic [SP_W-1:0] m_msp, m_psp;

    always #5 clk = ~clk;

    priv_mode_ctrl #(.SP_W(SP_W), .DEPTH_W(DEPTH_W)) dut (
        .clk(clk), .rst_n(rst_n), .exc_enter(exc_enter), .exc_return(exc_return),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .msp_we(msp_we), .msp_wdata(msp_wdata),
        .psp_we(psp_we), .psp_wdata(psp_wdata), .handler_mode(handler_mode),
        .user_level(user_level), .psp_active(psp_active), .ctrl_value(ctrl_value),
        .nest_depth(nest_depth), .exc_error(exc_error), .msp_value(msp_value),
        .psp_value(psp_value), .active_sp(active_sp)
    );

    task automatic chk(input string tag, input logic [SP_W-1:0] act, input logic [SP_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic hm;
        hm = (m_depth != 0);
        chk({tag, " mode"}, SP_W'(handler_mode), SP_W'(hm));
        chk({tag, " user"}, SP_W'(user_level), SP_W'(!hm && m_ctrl[0]));
        chk({tag, " psp"}, SP_W'(psp_active), SP_W'(!hm && m_ctrl[1]));
        chk({tag, " ctrl"}, SP_W'(ctrl_value), SP_W'(m_ctrl));
        chk({tag, " depth"}, SP_W'(nest_depth), SP_W'(m_depth));
        chk({tag, " err"}, SP_W'(exc_error), SP_W'(m_err));
        chk({tag, " msp"}, msp_value, m_msp);
        chk({tag, " psp_val"}, psp_value, m_psp);
        chk({tag, " active"}, active_sp, (!hm && m_ctrl[1]) ? m_psp : m_msp);
    endtask

    // one cycle: drive at negedge, update model, sample after posedge
    task automatic step(input logic en, input logic rt, input logic cw, input logic [1:0] cd,
                        input logic mw, input logic [SP_W-1:0] md,
                        input logic pw, input logic [SP_W-1:0] pd);
        @(negedge clk);
        exc_enter = en; exc_return = rt; ctrl_we = cw; ctrl_wdata = cd;
        msp_we = mw; msp_wdata = md; psp_we = pw; psp_wdata = pd;
        if (cw) begin
            if (m_depth != 0 || !m_ctrl[0]) m_ctrl = cd;
            else m_ctrl[1] = cd[1];
        end
        m_err = 1'b0;
        if (en) begin
            if (m_depth == MAXD) m_err = 1'b1; else m_depth++;
        end else if (rt) begin
            if (m_depth == 0) m_err = 1'b1; else m_depth--;
        end
        if (mw) m_msp = md & ~32'h3;
        if (pw) m_psp = pd & ~32'h3;
        @(posedge clk); #1;
        exc_enter = 0; exc_return = 0; ctrl_we = 0; msp_we = 0; psp_we = 0;
    endtask

    task automatic idle(); step(0, 0, 0, 2'b00, 0, '0, 0, '0); endtask
    task automatic wr_ctrl(input logic [1:0] d); step(0, 0, 1, d, 0, '0, 0, '0); endtask
    task automatic enter(); step(1, 0, 0, 2'b00, 0, '0, 0, '0); endtask
    task automatic leave(); step(0, 1, 0, 2'b00, 0, '0, 0, '0); endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        m_ctrl = 0; m_depth = 0; m_err = 0; m_msp = 0; m_psp = 0;
        @(posedge clk); @(posedge clk); #1;
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
    endtask

    initial begin
        #2000000;
        n_errors++; n_checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        check_all("R1 reset");

        // R3 R4: all start words x all writes
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 4; w++) begin
                do_reset();
                wr_ctrl(2'(s));
                check_all("R3 priv write");
                wr_ctrl(2'(w));
                check_all(s[0] ? "R4 user write" : "R3 priv write2");
                // R6 entry keeps ctrl, R2 handler privileged
                enter();
                check_all("R6 R2 entry");
                leave();
                check_all("R7 resume level");
            end
        end

        // R5: handler restores privilege for the return
        do_reset();
        wr_ctrl(2'b11);
        enter();
        wr_ctrl(2'b00);
        check_all("R5 handler write");
        leave();
        check_all("R5 R7 resumed privileged");
        enter();
        wr_ctrl(2'b01);
        leave();
        check_all("R5 handler lowers");

        // R7 R10 nesting to full depth and overflow
        do_reset();
        wr_ctrl(2'b11);
        for (int i = 0; i < MAXD; i++) begin
            enter();
            check_all("R6 nest up");
        end
        enter();
        check_all("R10 overflow");
        idle();
        check_all("R10 err one cycle");
        for (int i = 0; i < MAXD; i++) begin
            leave();
            check_all("R7 nest down");
        end

        // R9 stray return
        leave();
        check_all("R9 bad return");
        idle();
        check_all("R9 err clears");

        // R11 simultaneous pulses
        step(1, 1, 0, 2'b00, 0, '0, 0, '0);
        check_all("R11 enter wins thread");
        step(1, 1, 0, 2'b00, 0, '0, 0, '0);
        check_all("R11 enter wins handler");
        leave(); leave();
        check_all("R11 back to thread");

        // R8 alignment sweep and selection
        do_reset();
        for (int b = 0; b < 4; b++) begin
            step(0, 0, 0, 2'b00, 1, 32'h2000_0100 + 32'(b), 1, 32'h1000_0040 + 32'(b) + 32'h8);
            check_all("R8 align msp view");
        end
        wr_ctrl(2'b10);
        check_all("R8 psp view");
        enter();
        check_all("R8 R2 handler msp view");
        step(0, 0, 0, 2'b00, 0, '0, 1, 32'hFFFF_FFFF);
        check_all("R8 write in handler");
        leave();
        check_all("R8 back to psp");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule